// File: doc/BRIEF.md
# Dual-Role Cache Data Store

This block holds the data half of a four-way cache: 4 KB in four ways of 1 KB each. The cache controller reads and fills whole longwords through a way/index port with byte enables. A second, direct port reaches the same storage through a fixed 4 KB address window. The direct port takes byte, word and longword accesses and finishes each in one cycle. It uses only the internal cache-side path, so it keeps working while another master owns the external bus.

Two mode inputs decide how the storage is shared. With the cache off, the whole window is plain on-chip RAM. With the cache on in two-way mode, the lower two ways are plain RAM and the upper two ways serve the cache. With the cache on in four-way mode, every way belongs to the cache, and the direct port still reaches the array for inspection. When both ports request in the same cycle, the direct port wins.

Top module: `cache_data_store`

## Requirements
- R1: Way n is the direct-window range BASE+n*0x400 to BASE+n*0x400+0x3FF (BASE = 0xC0000000). Cache-port word `cq_idx` of way `cq_way` is the same storage as direct address BASE + cq_way*0x400 + 4*cq_idx. A direct access outside the window returns `dp_err` and writes nothing.
- R2: `dp_size` encodes 0 = byte, 1 = word, 2 = longword. Code 3 returns `dp_err` and writes nothing.
- R3: Storage is big-endian: byte offset 0 is bits 31:24 of a longword. Write data is right-justified in `dp_wdata`. Read data comes back right-justified and zero-extended in `dp_rdata`.
- R4: A byte or word write changes only the addressed byte lanes of the longword.
- R5: Every direct request gives `dp_ack` (with read data) or `dp_err` one cycle later. Without a request, both stay low.
- R6: A word access with address bit 0 set, or a longword access with address bits 1:0 non-zero, returns `dp_err` and leaves memory unchanged.
- R7: With `cache_en` low, every accepted direct access raises `dp_ram` together with `dp_ack`.
- R8: With `cache_en` high and `two_way` high, accepted direct accesses to ways 0 and 1 raise `dp_ram` and those to ways 2 and 3 do not. With `cache_en` high and `two_way` low, `dp_ram` stays low.
- R9: With the cache on, a cache-port access to a cache-owned way raises `cq_ack` one cycle later. A read returns the longword in `cq_rdata`. A write updates the lanes selected by `cq_be` (bit 3 = bits 31:24). A cache-port access while the cache is off, or to way 0 or 1 in two-way mode, raises `cq_err` and writes nothing.
- R10: When `dp_req` and `cq_req` are high together, `cq_wait` is high in that cycle. The cache request then gets neither `cq_ack` nor `cq_err` and has no effect; the direct access goes ahead.
- R11: After reset, `dp_ack`, `dp_err`, `dp_ram`, `cq_ack` and `cq_err` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cache_en | input | 1 | Cache enabled |
| two_way | input | 1 | Two-way cache mode |
| dp_req | input | 1 | Direct access request |
| dp_we | input | 1 | Direct access is a write |
| dp_size | input | 2 | 0 byte, 1 word, 2 longword |
| dp_addr | input | 32 | Direct byte address |
| dp_wdata | input | 32 | Right-justified write data |
| dp_ack | output | 1 | Direct access completed |
| dp_err | output | 1 | Direct access rejected |
| dp_ram | output | 1 | Completed access fell in plain-RAM area |
| dp_rdata | output | 32 | Right-justified read data |
| cq_req | input | 1 | Cache-port request |
| cq_we | input | 1 | Cache-port write |
| cq_way | input | 2 | Way select |
| cq_idx | input | 8 | Longword index within the way |
| cq_be | input | 4 | Byte enables, bit 3 = bits 31:24 |
| cq_wdata | input | 32 | Cache write longword |
| cq_wait | output | 1 | Cache request held off this cycle |
| cq_ack | output | 1 | Cache access completed |
| cq_err | output | 1 | Cache access refused by mode |
| cq_rdata | output | 32 | Cache read longword |

## Verification
Direct accesses and cache-port accesses can fall in the same cycle, and they may target the same longword. The bench raises both requests on one edge: the direct port writes a longword while the cache port tries to write a different value to the same word. It checks that `cq_wait` is high in that cycle, that only `dp_ack` follows, and that a later read returns the direct value. A retried cache write must then land normally.

// File: rtl/cache_data_store.sv
module cache_data_store #(
  parameter logic [31:0] BASE = 32'hC000_0000,
  parameter int WAYS = 4,
  parameter int WAY_BYTES = 1024
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        cache_en,
  input  logic        two_way,
  input  logic        dp_req,
  input  logic        dp_we,
  input  logic [1:0]  dp_size,
  input  logic [31:0] dp_addr,
  input  logic [31:0] dp_wdata,
  output logic        dp_ack,
  output logic        dp_err,
  output logic        dp_ram,
  output logic [31:0] dp_rdata,
  input  logic        cq_req,
  input  logic        cq_we,
  input  logic [$clog2(WAYS)-1:0] cq_way,
  input  logic [$clog2(WAY_BYTES/4)-1:0] cq_idx,
  input  logic [3:0]  cq_be,
  input  logic [31:0] cq_wdata,
  output logic        cq_wait,
  output logic        cq_ack,
  output logic        cq_err,
  output logic [31:0] cq_rdata
);
  localparam int WPW   = WAY_BYTES / 4;
  localparam int IDXW  = $clog2(WPW);
  localparam int WAYW  = $clog2(WAYS);
  localparam int AW    = IDXW + WAYW + 2;
  localparam int WORDS = WAYS * WPW;
  localparam int HALF  = WAYS / 2;

  logic [31:0] mem [WORDS];

  logic [1:0]      off;
  logic            in_win, size_ok, align_ok, dp_ok;
  logic [WAYW-1:0] dp_way;
  logic [3:0]      dp_lanes;
  logic [31:0]     dp_wword;
  logic            cq_ok, cq_go, dp_in_ram;

  assign off     = dp_addr[1:0];
  assign in_win  = dp_addr[31:AW] == BASE[31:AW];
  assign size_ok = dp_size != 2'd3;
  assign align_ok = (dp_size == 2'd0) ||
                    (dp_size == 2'd1 && !off[0]) ||
                    (dp_size == 2'd2 && off == 2'd0);
  assign dp_ok   = in_win && size_ok && align_ok;
  assign dp_way  = dp_addr[AW-1:AW-WAYW];

  always_comb begin
    case (dp_size)
      2'd0:    begin dp_lanes = 4'b1000 >> off;              dp_wword = {4{dp_wdata[7:0]}};  end
      2'd1:    begin dp_lanes = off[1] ? 4'b0011 : 4'b1100;  dp_wword = {2{dp_wdata[15:0]}}; end
      default: begin dp_lanes = 4'b1111;                     dp_wword = dp_wdata;            end
    endcase
  end

  assign dp_in_ram = !cache_en || (two_way && int'(dp_way) < HALF);
  assign cq_ok     = cache_en && !(two_way && int'(cq_way) < HALF);
  assign cq_wait   = cq_req && dp_req;
  assign cq_go     = cq_req && !dp_req && cq_ok;

  logic [WAYW+IDXW-1:0] acc_idx;
  logic [3:0]           wr_lanes;
  logic [31:0]          wr_word;
  logic                 wr_en;

  always_comb begin
    if (dp_req) begin
      acc_idx  = dp_addr[AW-1:2];
      wr_en    = dp_we && dp_ok;
      wr_lanes = dp_lanes;
      wr_word  = dp_wword;
    end else begin
      acc_idx  = {cq_way, cq_idx};
      wr_en    = cq_go && cq_we;
      wr_lanes = cq_be;
      wr_word  = cq_wdata;
    end
  end

  always_ff @(posedge clk) begin
    if (wr_en)
      for (int b = 0; b < 4; b++)
        if (wr_lanes[b]) mem[acc_idx][8*b +: 8] <= wr_word[8*b +: 8];
  end

  logic [31:0] rd_word;
  logic [1:0]  size_q, off_q;

  always_ff @(posedge clk) begin
    rd_word <= mem[acc_idx];
    size_q  <= dp_size;
    off_q   <= off;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dp_ack <= 1'b0;
      dp_err <= 1'b0;
      dp_ram <= 1'b0;
      cq_ack <= 1'b0;
      cq_err <= 1'b0;
    end else begin
      dp_ack <= dp_req && dp_ok;
      dp_err <= dp_req && !dp_ok;
      dp_ram <= dp_req && dp_ok && dp_in_ram;
      cq_ack <= cq_go;
      cq_err <= cq_req && !dp_req && !cq_ok;
    end
  end

  logic [31:0] dp_fmt;
  always_comb begin
    case (size_q)
      2'd0:    dp_fmt = {24'b0, rd_word[8*(3-int'(off_q)) +: 8]};
      2'd1:    dp_fmt = off_q[1] ? {16'b0, rd_word[15:0]} : {16'b0, rd_word[31:16]};
      default: dp_fmt = rd_word;
    endcase
  end

  assign dp_rdata = dp_ack ? dp_fmt : 32'b0;
  assign cq_rdata = cq_ack ? rd_word : 32'b0;
endmodule

module cache_data_store_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        cache_en,
  input logic        dp_req,
  input logic [1:0]  dp_size,
  input logic [31:0] dp_addr,
  input logic        dp_ack,
  input logic        dp_err,
  input logic        dp_ram,
  input logic        cq_req,
  input logic        cq_ack,
  input logic        cq_err
);
  AST_DP_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    dp_req |=> (dp_ack ^ dp_err)); // R5
  AST_DP_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !dp_req |=> (!dp_ack && !dp_err)); // R5
  AST_LONG_MISALIGN: assert property (@(posedge clk) disable iff (!rst_n)
    (dp_req && dp_size == 2'd2 && dp_addr[1:0] != 2'd0) |=> dp_err); // R6
  AST_WORD_MISALIGN: assert property (@(posedge clk) disable iff (!rst_n)
    (dp_req && dp_size == 2'd1 && dp_addr[0]) |=> dp_err); // R6
  AST_BAD_SIZE: assert property (@(posedge clk) disable iff (!rst_n)
    (dp_req && dp_size == 2'd3) |=> dp_err); // R2
  AST_RAM_WITH_ACK: assert property (@(posedge clk) disable iff (!rst_n)
    dp_ram |-> dp_ack); // R7
  AST_DIRECT_PRIORITY: assert property (@(posedge clk) disable iff (!rst_n)
    (dp_req && cq_req) |=> (!cq_ack && !cq_err)); // R10
  AST_CQ_OFF_REFUSED: assert property (@(posedge clk) disable iff (!rst_n)
    (cq_req && !dp_req && !cache_en) |=> cq_err); // R9
  AST_CQ_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(cq_ack && cq_err)); // R9
endmodule

bind cache_data_store cache_data_store_chk u_chk (
  .clk(clk), .rst_n(rst_n), .cache_en(cache_en), .dp_req(dp_req),
  .dp_size(dp_size), .dp_addr(dp_addr), .dp_ack(dp_ack), .dp_err(dp_err),
  .dp_ram(dp_ram), .cq_req(cq_req), .cq_ack(cq_ack), .cq_err(cq_err)
);

// File: tb/cache_data_store_bench.sv
module cache_data_store_bench;
  localparam logic [31:0] B = 32'hC000_0000;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cache_en = 1'b0, two_way = 1'b0;
  logic dp_req = 1'b0, dp_we = 1'b0;
  logic [1:0] dp_size = 2'd0;
  logic [31:0] dp_addr = 32'd0, dp_wdata = 32'd0;
  logic dp_ack, dp_err, dp_ram;
  logic [31:0] dp_rdata;
  logic cq_req = 1'b0, cq_we = 1'b0;
  logic [1:0] cq_way = 2'd0;
  logic [7:0] cq_idx = 8'd0;
  logic [3:0] cq_be = 4'd0;
  logic [31:0] cq_wdata = 32'd0;
  logic cq_wait, cq_ack, cq_err;
  logic [31:0] cq_rdata;

  int total = 0, bad = 0;
  bit done = 0;
  logic r_ack, r_err, r_ram, c_ack, c_err;
  logic [31:0] r_data, c_data;

  always #2 clk = ~clk;

  cache_data_store u_cache_data_store (
    .clk(clk), .rst_n(rst_n), .cache_en(cache_en), .two_way(two_way),
    .dp_req(dp_req), .dp_we(dp_we), .dp_size(dp_size), .dp_addr(dp_addr),
    .dp_wdata(dp_wdata), .dp_ack(dp_ack), .dp_err(dp_err), .dp_ram(dp_ram),
    .dp_rdata(dp_rdata), .cq_req(cq_req), .cq_we(cq_we), .cq_way(cq_way),
    .cq_idx(cq_idx), .cq_be(cq_be), .cq_wdata(cq_wdata), .cq_wait(cq_wait),
    .cq_ack(cq_ack), .cq_err(cq_err), .cq_rdata(cq_rdata)
  );

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic dp(logic we, logic [1:0] sz, logic [31:0] a, logic [31:0] wd);
    @(negedge clk);
    dp_req = 1'b1; dp_we = we; dp_size = sz; dp_addr = a; dp_wdata = wd;
    @(negedge clk);
    r_ack = dp_ack; r_err = dp_err; r_ram = dp_ram; r_data = dp_rdata;
    dp_req = 1'b0; dp_we = 1'b0;
  endtask

  task automatic cq(logic we, logic [1:0] w, logic [7:0] i, logic [3:0] be, logic [31:0] wd);
    @(negedge clk);
    cq_req = 1'b1; cq_we = we; cq_way = w; cq_idx = i; cq_be = be; cq_wdata = wd;
    @(negedge clk);
    c_ack = cq_ack; c_err = cq_err; c_data = cq_rdata;
    cq_req = 1'b0; cq_we = 1'b0;
  endtask

  task automatic t_reset;
    chk("R11 dp_ack", dp_ack, 0);
    chk("R11 dp_err", dp_err, 0);
    chk("R11 dp_ram", dp_ram, 0);
    chk("R11 cq_ack", cq_ack, 0);
    chk("R11 cq_err", cq_err, 0);
  endtask

  task automatic t_longword;
    cache_en = 0;
    dp(1, 2'd2, B + 32'h10, 32'h1122_3344);
    chk("R5 write ack", r_ack, 1);
    chk("R7 write ram", r_ram, 1);
    dp(0, 2'd2, B + 32'h10, 0);
    chk("R5 read ack", r_ack, 1);
    chk("R5 read data", r_data, 32'h1122_3344);
    @(negedge clk);
    chk("R5 idle ack", dp_ack, 0);
  endtask

  task automatic t_endian;
    dp(0, 2'd0, B + 32'h10, 0); chk("R3 byte0", r_data, 32'h11);
    dp(0, 2'd0, B + 32'h11, 0); chk("R3 byte1", r_data, 32'h22);
    dp(0, 2'd0, B + 32'h13, 0); chk("R3 byte3", r_data, 32'h44);
    dp(0, 2'd1, B + 32'h10, 0); chk("R3 word0", r_data, 32'h1122);
    dp(0, 2'd1, B + 32'h12, 0); chk("R3 word2", r_data, 32'h3344);
  endtask

  task automatic t_partial;
    dp(1, 2'd0, B + 32'h11, 32'hFFFF_FFAA);
    dp(0, 2'd2, B + 32'h10, 0); chk("R4 byte lane", r_data, 32'h11AA_3344);
    dp(1, 2'd1, B + 32'h12, 32'h1234_BEEF);
    dp(0, 2'd2, B + 32'h10, 0); chk("R4 word lane", r_data, 32'h11AA_BEEF);
  endtask

  task automatic t_misalign;
    dp(1, 2'd1, B + 32'h11, 32'h0000_5555);
    chk("R6 word err", r_err, 1);
    chk("R6 word no ack", r_ack, 0);
    dp(1, 2'd2, B + 32'h12, 32'h6666_6666);
    chk("R6 long err", r_err, 1);
    dp(1, 2'd3, B + 32'h10, 32'h7777_7777);
    chk("R2 size3 err", r_err, 1);
    dp(0, 2'd2, B + 32'h10, 0);
    chk("R6 memory kept", r_data, 32'h11AA_BEEF);
  endtask

  task automatic t_window;
    dp(1, 2'd2, B + 32'h1010, 32'hDEAD_DEAD);
    chk("R1 above window err", r_err, 1);
    dp(1, 2'd2, 32'hB000_0010, 32'hDEAD_DEAD);
    chk("R1 below window err", r_err, 1);
    dp(0, 2'd2, B + 32'h10, 0);
    chk("R1 alias not written", r_data, 32'h11AA_BEEF);
    dp(1, 2'd2, B + 32'hFFC, 32'hCAFE_F00D);
    cache_en = 1; two_way = 0;
    cq(0, 2'd3, 8'd255, 4'hF, 0);
    chk("R1 way3 last ack", c_ack, 1);
    chk("R1 way3 last data", c_data, 32'hCAFE_F00D);
  endtask

  task automatic t_modes;
    cache_en = 0;
    dp(1, 2'd2, B, 32'h0102_0304);
    cache_en = 1; two_way = 1;
    dp(0, 2'd2, B, 0);
    chk("R8 way0 ram", r_ram, 1);
    dp(0, 2'd2, B + 32'h800, 0);
    chk("R8 way2 ack", r_ack, 1);
    chk("R8 way2 not ram", r_ram, 0);
    two_way = 0;
    dp(0, 2'd2, B, 0);
    chk("R8 four-way no ram", r_ram, 0);
    chk("R8 four-way data", r_data, 32'h0102_0304);
    two_way = 1;
    cq(1, 2'd0, 8'd0, 4'hF, 32'hBAD0_BAD0);
    chk("R9 ram way refused", c_err, 1);
    chk("R9 ram way no ack", c_ack, 0);
    dp(0, 2'd2, B, 0);
    chk("R9 ram way kept", r_data, 32'h0102_0304);
    cq(1, 2'd2, 8'd6, 4'b0110, 32'hAABB_CCDD);
    chk("R9 cache write ack", c_ack, 1);
    dp(1, 2'd2, B + 32'h820, 32'h0);
    cq(1, 2'd2, 8'd8, 4'b0110, 32'hAABB_CCDD);
    dp(0, 2'd2, B + 32'h820, 0);
    chk("R9 byte enables", r_data, 32'h00BB_CC00);
    cache_en = 0;
    cq(0, 2'd3, 8'd255, 4'hF, 0);
    chk("R9 cache off refused", c_err, 1);
    cache_en = 1; two_way = 0;
  endtask

  task automatic t_collision;
    @(negedge clk);
    dp_req = 1; dp_we = 1; dp_size = 2'd2; dp_addr = B + 32'h814; dp_wdata = 32'h5A5A_0001;
    cq_req = 1; cq_we = 1; cq_way = 2'd2; cq_idx = 8'd5; cq_be = 4'hF; cq_wdata = 32'hA5A5_0002;
    #1;
    chk("R10 wait high", cq_wait, 1);
    @(negedge clk);
    chk("R10 direct ack", dp_ack, 1);
    chk("R10 no cache ack", cq_ack, 0);
    chk("R10 no cache err", cq_err, 0);
    dp_req = 0; dp_we = 0; cq_req = 0; cq_we = 0;
    dp(0, 2'd2, B + 32'h814, 0);
    chk("R10 direct wins", r_data, 32'h5A5A_0001);
    cq(1, 2'd2, 8'd5, 4'hF, 32'hA5A5_0002);
    chk("R10 retry ack", c_ack, 1);
    dp(0, 2'd2, B + 32'h814, 0);
    chk("R10 retry lands", r_data, 32'hA5A5_0002);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1;
      total++; bad++;
      $display("FAIL watchdog actual=%h expected=%h", 0, 1);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset;
    t_longword;
    t_endian;
    t_partial;
    t_misalign;
    t_window;
    t_modes;
    t_collision;
    if (!done) begin
      done = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule